// File: doc/BRIEF.md
# Pipelined Gradient Magnitude Unit

This block takes a three-component gradient vector, with each component a signed two's-complement integer. It returns the integer length of the vector: the truncated square root of the sum of the three squares. It accepts one vector per clock and returns one result per clock. Each result appears a fixed number of cycles later, with a valid flag that follows the input flag through the pipeline.

Two stages form the squared length. The first takes the absolute value of each component and squares it. The second adds the three squares into an unsigned sum that is twice the component width. A restoring square-root pipeline then reduces that sum to a root with as many bits as one component:

- The most significant root bit comes straight from the two highest bits of the sum.
- Each later stage appends the next pair of sum bits to its remainder.
- It compares the result with four times the partial root plus one.
- When the remainder is large enough, it subtracts that value and sets the root bit.

Every stage is a register stage. With the default 17-bit components, the sum is 34 bits, the root is 17 bits and the latency is 19 cycles.

Top module: `gradient_magnitude`

## Requirements
- R1: `out_valid` is high exactly `COMP_W + 2` cycles after each cycle in which `in_valid` was high, and is low otherwise.
- R2: Each result equals floor(sqrt(x² + y² + z²)), where x, y and z are the two's-complement values of the components.
- R3: The sum of squares is exact for every input, including the most negative component value and all-ones bit patterns, so the result never wraps.
- R4: The most significant root bit is 1 exactly when the sum is at least 2^(2·COMP_W − 2). For example, (−65536, 0, 0) gives 65536 and (65535, 361, 0) gives 65535.
- R5: When a trial comparison fails, the remainder is kept unchanged. A sum of n² − 1 therefore yields n − 1, and at every stage the remainder stays at most twice the partial root.
- R6: While reset is asserted and after it is released, `out_valid` and `out_mag` are 0 until the first result arrives.
- R7: A zero vector yields 0, and a vector whose squared length is a perfect square n² yields exactly n.
- R8: Valid inputs on consecutive clocks each produce their own result on consecutive clocks, in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a gradient vector on the component inputs |
| grad_x | input | COMP_W | X component, signed |
| grad_y | input | COMP_W | Y component, signed |
| grad_z | input | COMP_W | Z component, signed |
| out_valid | output | 1 | Marks a magnitude on `out_mag` |
| out_mag | output | COMP_W | Truncated integer magnitude |

## Verification
The assertions assume that every valid input leaves the pipeline after the fixed latency. They also rely on the component width bounding the sum of squares by three times the square of the most negative value, so remainder and root-exactness checks only ever see sums that can really arise. The stimulus keeps within that bound by drawing components only from the signed range of the configured width. A 4-bit instance is swept over every triple of components, back to back, with occasional idle cycles. A full-width instance receives directed corner vectors (extremes, perfect squares and values one below them) and random vectors.

// File: rtl/gm_pkg.sv
package gm_pkg;
    // Default signed component width; sum and root widths derive from it.
    localparam int unsigned GM_COMP_W_DEF = 17;

    function automatic int unsigned gm_sum_width(int unsigned comp_w);
        return 2 * comp_w;
    endfunction
endpackage

// File: rtl/gm_square_sum.sv
module gm_square_sum #(
    parameter int unsigned COMP_W = gm_pkg::GM_COMP_W_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic signed [COMP_W-1:0]          comp_x,
    input  logic signed [COMP_W-1:0]          comp_y,
    input  logic signed [COMP_W-1:0]          comp_z,
    output logic                              sum_valid,
    output logic [gm_pkg::gm_sum_width(COMP_W)-1:0] sum_sq
);
    localparam int unsigned SQ_W  = 2 * COMP_W;
    localparam int unsigned SUM_W = gm_pkg::gm_sum_width(COMP_W);
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(3) << (2 * COMP_W - 2);

    typedef struct packed {
        logic                       v;
        logic [2:0][SQ_W-1:0]       sq;
    } sq_stage_t;

    typedef struct packed {
        logic                       v;
        logic [SUM_W-1:0]           sum;
    } add_stage_t;

    sq_stage_t  sq_d,  sq_q;
    add_stage_t add_d, add_q;

    logic [2:0][COMP_W-1:0] comps;
    assign comps = {comp_z, comp_y, comp_x};

    always_comb begin
        sq_d.v = in_valid;
        for (int i = 0; i < 3; i++) begin
            logic [COMP_W-1:0] mag;
            mag = comps[i][COMP_W-1] ? (~comps[i] + 1'b1) : comps[i];
            sq_d.sq[i] = SQ_W'(mag) * SQ_W'(mag);
        end
        add_d.v   = sq_q.v;
        add_d.sum = SUM_W'(sq_q.sq[0]) + SUM_W'(sq_q.sq[1]) + SUM_W'(sq_q.sq[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q  <= '0;
            add_q <= '0;
        end else begin
            sq_q  <= sq_d;
            add_q <= add_d;
        end
    end

    assign sum_valid = add_q.v;
    assign sum_sq    = add_q.sum;

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        add_q.v |-> (add_q.sum <= SUM_MAX)); // R3
endmodule

// File: rtl/gm_root_step.sv
module gm_root_step #(
    parameter int unsigned SUM_W  = 34,
    parameter int unsigned ROOT_W = 17,
    parameter int unsigned BIT    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic [SUM_W-1:0]     in_rad,
    input  logic [ROOT_W-1:0]    in_root,
    input  logic [ROOT_W:0]      in_rem,
    output logic                 out_v,
    output logic [SUM_W-1:0]     out_rad,
    output logic [ROOT_W-1:0]    out_root,
    output logic [ROOT_W:0]      out_rem
);
    localparam int unsigned REM_W = ROOT_W + 1;
    localparam int unsigned EXT_W = ROOT_W + 3;

    typedef struct packed {
        logic                v;
        logic [SUM_W-1:0]    rad;
        logic [ROOT_W-1:0]   root;
        logic [REM_W-1:0]    rem;
    } step_t;

    step_t st_d, st_q;
    logic [EXT_W-1:0] ext_rem, trial;

    always_comb begin
        ext_rem = {in_rem, in_rad[2*BIT+1 -: 2]};
        trial   = {1'b0, in_root, 2'b01};
        st_d.v   = in_v;
        st_d.rad = in_rad;
        if (ext_rem >= trial) begin
            st_d.rem  = REM_W'(ext_rem - trial);
            st_d.root = {in_root[ROOT_W-2:0], 1'b1};
        end else begin
            st_d.rem  = REM_W'(ext_rem);
            st_d.root = {in_root[ROOT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_v    = st_q.v;
    assign out_rad  = st_q.rad;
    assign out_root = st_q.root;
    assign out_rem  = st_q.rem;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> (st_q.rem <= {st_q.root, 1'b0})); // R5
endmodule

// File: rtl/gm_isqrt_pipe.sv
module gm_isqrt_pipe #(
    parameter int unsigned SUM_W = 34
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_v,
    input  logic [SUM_W-1:0]       in_rad,
    output logic                   out_v,
    output logic [SUM_W/2-1:0]     out_root
);
    localparam int unsigned ROOT_W = SUM_W / 2;
    localparam int unsigned REM_W  = ROOT_W + 1;
    localparam int unsigned CHK_W  = SUM_W + 2;

    typedef struct packed {
        logic                v;
        logic [SUM_W-1:0]    rad;
        logic [ROOT_W-1:0]   root;
        logic [REM_W-1:0]    rem;
    } head_t;

    head_t head_d, head_q;

    always_comb begin
        logic [1:0] top2;
        top2        = in_rad[SUM_W-1 -: 2];
        head_d.v    = in_v;
        head_d.rad  = in_rad;
        head_d.root = ROOT_W'(|top2);
        head_d.rem  = REM_W'(top2 - {1'b0, |top2});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= head_d;
    end

    logic              st_v    [ROOT_W];
    logic [SUM_W-1:0]  st_rad  [ROOT_W];
    logic [ROOT_W-1:0] st_root [ROOT_W];
    logic [REM_W-1:0]  st_rem  [ROOT_W];

    assign st_v[0]    = head_q.v;
    assign st_rad[0]  = head_q.rad;
    assign st_root[0] = head_q.root;
    assign st_rem[0]  = head_q.rem;

    for (genvar j = 1; j < ROOT_W; j++) begin : g_step
        gm_root_step #(
            .SUM_W (SUM_W),
            .ROOT_W(ROOT_W),
            .BIT   (ROOT_W - 1 - j)
        ) step_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (st_v[j-1]),
            .in_rad  (st_rad[j-1]),
            .in_root (st_root[j-1]),
            .in_rem  (st_rem[j-1]),
            .out_v   (st_v[j]),
            .out_rad (st_rad[j]),
            .out_root(st_root[j]),
            .out_rem (st_rem[j])
        );
    end

    assign out_v    = st_v[ROOT_W-1];
    assign out_root = st_root[ROOT_W-1];

    logic [CHK_W-1:0] chk_sq, chk_next, chk_rad;
    always_comb begin
        chk_sq   = CHK_W'(out_root) * CHK_W'(out_root);
        chk_next = chk_sq + (CHK_W'(out_root) << 1) + CHK_W'(1);
        chk_rad  = CHK_W'(st_rad[ROOT_W-1]);
    end

    AST_ROOT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> ((chk_sq <= chk_rad) && (chk_rad < chk_next))); // R2
endmodule

// File: rtl/gradient_magnitude.sv
module gradient_magnitude #(
    parameter int unsigned COMP_W = gm_pkg::GM_COMP_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COMP_W-1:0] grad_x,
    input  logic signed [COMP_W-1:0] grad_y,
    input  logic signed [COMP_W-1:0] grad_z,
    output logic                     out_valid,
    output logic [COMP_W-1:0]        out_mag
);
    localparam int unsigned SUM_W   = gm_pkg::gm_sum_width(COMP_W);
    localparam int unsigned LATENCY = COMP_W + 2;
    localparam int unsigned CNT_W   = $clog2(LATENCY + 1) + 1;

    logic             sum_valid;
    logic [SUM_W-1:0] sum_sq;

    gm_square_sum #(.COMP_W(COMP_W)) sqsum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .comp_x   (grad_x),
        .comp_y   (grad_y),
        .comp_z   (grad_z),
        .sum_valid(sum_valid),
        .sum_sq   (sum_sq)
    );

    gm_isqrt_pipe #(.SUM_W(SUM_W)) root_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (sum_valid),
        .in_rad  (sum_sq),
        .out_v   (out_valid),
        .out_root(out_mag)
    );

    // Occupancy tracker for the latency property only.
    logic [CNT_W-1:0] inflight_d, inflight_q;

    always_comb begin
        inflight_d = inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_d;
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LATENCY)); // R1
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0)); // R1
endmodule

// File: tb/gradient_magnitude_tb_top.sv
`timescale 1ns/1ps
module gradient_magnitude_tb_top;
    localparam int SW   = 4;
    localparam int BW   = 17;
    localparam int SLAT = SW + 2;
    localparam int BLAT = BW + 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic s_in_v, b_in_v, s_out_v, b_out_v;
    logic signed [SW-1:0] s_x, s_y, s_z;
    logic signed [BW-1:0] b_x, b_y, b_z;
    logic [SW-1:0] s_mag;
    logic [BW-1:0] b_mag;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    longint s_exp[$]; int s_when[$]; string s_tag[$];
    longint b_exp[$]; int b_when[$]; string b_tag[$];

    gradient_magnitude #(.COMP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(s_in_v),
        .grad_x(s_x), .grad_y(s_y), .grad_z(s_z),
        .out_valid(s_out_v), .out_mag(s_mag)
    );

    gradient_magnitude #(.COMP_W(BW)) dut_big_i (
        .clk(clk), .rst_n(rst_n), .in_valid(b_in_v),
        .grad_x(b_x), .grad_y(b_y), .grad_z(b_z),
        .out_valid(b_out_v), .out_mag(b_mag)
    );

    function automatic longint isqrt(longint v);
        longint r = 0;
        for (int b = 20; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic score_one(bit ov, longint mag, int lat,
                             ref longint eq[$], ref int wq[$], ref string tq[$]);
        if (ov) begin
            if (eq.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", 1, 0);
            end else begin
                longint e = eq.pop_front();
                int w     = wq.pop_front();
                string t  = tq.pop_front();
                check(cyc == w + lat, "R1 latency", cyc - w, lat);
                check(mag == e, t, mag, e);
            end
        end else if (wq.size() != 0 && wq[0] + lat <= cyc) begin
            check(1'b0, "R1 missing out_valid", 0, 1);
            void'(eq.pop_front()); void'(wq.pop_front()); void'(tq.pop_front());
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        score_one(s_out_v, longint'(s_mag), SLAT, s_exp, s_when, s_tag);
        score_one(b_out_v, longint'(b_mag), BLAT, b_exp, b_when, b_tag);
    endtask

    task automatic drive_s(bit v, int x, int y, int z, string tag);
        s_in_v = v;
        s_x = SW'(x); s_y = SW'(y); s_z = SW'(z);
        if (v) begin
            s_exp.push_back(isqrt(longint'(x*x + y*y + z*z)));
            s_when.push_back(cyc);
            s_tag.push_back(tag);
        end
    endtask

    task automatic drive_b(bit v, int x, int y, int z, string tag);
        b_in_v = v;
        b_x = BW'(x); b_y = BW'(y); b_z = BW'(z);
        if (v) begin
            b_exp.push_back(isqrt(longint'(x)*x + longint'(y)*y + longint'(z)*z));
            b_when.push_back(cyc);
            b_tag.push_back(tag);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n = 0;
        rst_n = 1'b0;
        drive_s(1'b0, 0, 0, 0, "");
        drive_b(1'b0, 0, 0, 0, "");
        for (int i = 0; i < 3; i++) step();
        // R6: outputs idle in reset
        check(s_out_v == 1'b0 && s_mag == '0, "R6 reset small", s_mag, 0);
        check(b_out_v == 1'b0 && b_mag == '0, "R6 reset big", b_mag, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check(b_out_v == 1'b0 && b_mag == '0, "R6 after reset", b_mag, 0);
        end

        // Exhaustive back-to-back sweep on the narrow instance: R2 R8
        for (int x = -8; x < 8; x++)
            for (int y = -8; y < 8; y++)
                for (int z = -8; z < 8; z++) begin
                    step();
                    drive_s(1'b1, x, y, z, "R2 R8 sweep");
                    n++;
                    if (n % 37 == 0) begin
                        step();
                        drive_s(1'b0, 0, 0, 0, "");
                    end
                end
        step();
        drive_s(1'b0, 0, 0, 0, "");
        for (int i = 0; i < SLAT + 3; i++) step();

        // Directed corners on the full-width instance
        step(); drive_b(1'b1, 0, 0, 0, "R7 zero");
        step(); drive_b(1'b1, 3, 4, 0, "R7 perfect square 25");
        step(); drive_b(1'b1, 12, 16, 21, "R7 perfect square 841");
        step(); drive_b(1'b1, 2, 3, 6, "R7 perfect square 49");
        step(); drive_b(1'b1, 4, 2, 2, "R5 one below 25");
        step(); drive_b(1'b1, 4, 4, 4, "R5 one below 49");
        step(); drive_b(1'b1, -1, -1, -1, "R3 all-ones bits");
        step(); drive_b(1'b1, -65536, -65536, -65536, "R3 most negative");
        step(); drive_b(1'b1, 65535, 65535, 65535, "R3 most positive");
        step(); drive_b(1'b1, -65536, 65535, -1, "R3 mixed extremes");
        step(); drive_b(1'b1, -65536, 0, 0, "R4 top bit set");
        step(); drive_b(1'b1, 65535, 361, 0, "R4 top bit clear");
        step(); drive_b(1'b1, 0, -3, 0, "R2 single negative");
        for (int i = 0; i < 300; i++) begin
            step();
            drive_b(1'b1, int'($urandom_range(0, 131071)) - 65536,
                          int'($urandom_range(0, 131071)) - 65536,
                          int'($urandom_range(0, 131071)) - 65536, "R2 R8 random");
        end
        step();
        drive_b(1'b0, 0, 0, 0, "");
        for (int i = 0; i < BLAT + 3; i++) step();

        check(s_exp.size() == 0 && b_exp.size() == 0, "R1 drained",
              s_exp.size() + b_exp.size(), 0);
        finish_run();
    end
endmodule